// File: doc/BRIEF.md
# Serial-Input DAC Register Front End

This block is the digital side of a current-output converter. It receives a three-wire serial stream (an active-low select, a serial clock and a data line) and runs entirely on a fast system clock. All three wires are first passed through two-flop synchronisers, and their edges are then detected from the synchronised copies. While select is low, each rising edge of the serial clock moves one data bit into a shift register, most significant bit first.

When select returns high, the shift register is copied into a parallel holding register that feeds the converter. A single-cycle strobe marks each copy. The frame length is not fixed. Only the newest N bits survive, where N is 16 or 14 and is chosen by a parameter. A longer frame therefore loses its oldest bits, and a 14-bit build can take a 16-bit frame. The system clock has to run at least four times as fast as the serial clock.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset the output word is zero, the update strobe is low, and the shift register holds zero, so a release with no bits clocked presents zero.
- R2: While select is low, each rising edge of the serial clock shifts the data bit into bit 0 and moves the older bits toward the most significant end. An N-bit frame ending in a release therefore appears unchanged on the output word.
- R3: Serial clock edges while select is high leave the shift register unchanged.
- R4: A frame longer than N bits keeps only its final N bits. A 14-bit build given a 16-bit frame outputs the low 14 bits of that frame.
- R5: The output word changes only on a select release. It holds its value throughout a frame while bits are being clocked in.
- R6: Each select release produces exactly one update strobe, one system clock wide.
- R7: A release with no bits clocked transfers the current shift-register contents again.
- R8: A frame shorter than N bits shifts the new bits into the previous contents, so the result is the old value shifted left by the frame length with the new bits placed at the low end.
- R9: A serial clock rise that is sampled in the same system cycle as the select rise is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; its rising edge loads the output word |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| dacWord | output | DATA_BITS | Holding register that drives the converter |
| updateStb | output | 1 | One-cycle pulse when dacWord is loaded |

## Verification
The bench builds two copies side by side from the same wires. One uses the default 16-bit width and the other uses 14 bits, so every frame is checked against both truncation rules at once. Random frame lengths from zero to twenty bits cover short, exact, overlong and empty frames under each width. Directed cases cover clock activity with select high and a clock rise that coincides with the select rise.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic shiftEn;  // take one serial bit
    logic loadEn;   // copy shift register to the output word
  } feStrobe_t;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= RESET_VAL;
          else       pipe[s] <= din;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= RESET_VAL;
          else       pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dac_fe_ctrl.sv
module dac_fe_ctrl
  import dac_fe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      sclkS,
  output feStrobe_t stb
);
  logic csPrev;
  logic sclkPrev;
  logic sclkRise;
  logic csRise;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end

  assign sclkRise = sclkS & ~sclkPrev;
  assign csRise   = csS & ~csPrev;

  // A clock rise seen with select already high (including the release sample) is dropped
  always_comb begin
    stb.shiftEn = sclkRise & ~csS;
    stb.loadEn  = csRise;
  end

  // R6
  load_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadEn |=> !stb.loadEn);

  // R3
  shift_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csPrev && csS) |-> !stb.shiftEn);
endmodule

// File: rtl/dac_fe_datapath.sv
module dac_fe_datapath
  import dac_fe_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  feStrobe_t            stb,
  input  logic                 sdiS,
  output logic [DATA_BITS-1:0] dacWord,
  output logic                 updateStb
);
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[DATA_BITS-2:0], sdiS};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      dacWord   <= '0;
      updateStb <= 1'b0;
    end else begin
      updateStb <= stb.loadEn;
      if (stb.loadEn) dacWord <= shiftReg;
    end

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadEn |=> $stable(dacWord));

  // R2
  dac_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadEn |=> (updateStb && dacWord == $past(shiftReg)));

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shiftEn |=> $stable(shiftReg));

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb);
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import dac_fe_pkg::*;
#(
  parameter int DATA_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic [DATA_BITS-1:0] dacWord,
  output logic                 updateStb
);
  localparam int SYNC_WIDTH = 3;
  localparam logic [SYNC_WIDTH-1:0] SYNC_IDLE = 3'b100;  // select idles high

  logic [SYNC_WIDTH-1:0] syncOut;
  feStrobe_t             stb;

  dac_fe_sync #(
    .WIDTH(SYNC_WIDTH), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_IDLE)
  ) u_sync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, sdi}), .dout(syncOut)
  );

  dac_fe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csS(syncOut[2]), .sclkS(syncOut[1]), .stb(stb)
  );

  dac_fe_datapath #(.DATA_BITS(DATA_BITS)) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiS(syncOut[0]),
    .dacWord(dacWord), .updateStb(updateStb)
  );
endmodule

// File: tb/test_serial_dac_frontend.sv
module test_serial_dac_frontend;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [15:0] dacWide;
  logic [13:0] dacNarrow;
  logic stbWide, stbNarrow;

  int checks = 0;
  int errors = 0;
  int cntWide = 0, cntNarrow = 0, wideViol = 0;
  logic prevWide = 1'b0, prevNarrow = 1'b0;
  logic [15:0] shW = '0;
  logic [13:0] shN = '0;

  always #4 clk = ~clk;

  serial_dac_frontend #(.DATA_BITS(16)) i_serial_dac_frontend (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .dacWord(dacWide), .updateStb(stbWide));

  serial_dac_frontend #(.DATA_BITS(14)) i_serial_dac_frontend_narrow (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .dacWord(dacNarrow), .updateStb(stbNarrow));

  always @(negedge clk) begin
    if (stbWide) cntWide++;
    if (stbNarrow) cntNarrow++;
    if ((stbWide && prevWide) || (stbNarrow && prevNarrow)) wideViol++;
    prevWide = stbWide;
    prevNarrow = stbNarrow;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(logic b);
    sdi = b; cyc(4);
    sclk = 1'b1; cyc(4);
    sclk = 1'b0;
    shW = {shW[14:0], b};
    shN = {shN[12:0], b};
  endtask

  // Drive a frame of len bits, MSB first, then release and check both builds
  task automatic frame(logic [31:0] val, int len, string req);
    int w0 = cntWide, n0 = cntNarrow;
    logic [15:0] oldW = dacWide;
    logic [13:0] oldN = dacNarrow;
    csN = 1'b0; cyc(4);
    for (int i = len - 1; i >= 0; i--) clockBit(val[i]);
    cyc(4);
    check({req, " R5 hold wide"}, 32'(dacWide), 32'(oldW));
    check({req, " R5 hold narrow"}, 32'(dacNarrow), 32'(oldN));
    csN = 1'b1; cyc(8);
    check({req, " wide word"}, 32'(dacWide), 32'(shW));
    check({req, " narrow word"}, 32'(dacNarrow), 32'(shN));
    check({req, " R6 strobe count"}, 32'((cntWide - w0) + (cntNarrow - n0)), 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rstN = 1'b1;
    cyc(4);
    // R1 reset state
    check("R1 wide word", 32'(dacWide), 32'd0);
    check("R1 narrow word", 32'(dacNarrow), 32'd0);
    check("R1 strobe", 32'(stbWide | stbNarrow), 32'd0);
    // R7 empty frame right after reset shows zero shift register (R1)
    frame(32'd0, 0, "R7 R1 empty");
    // R2 exact-width frame
    frame(32'hA5C3, 16, "R2 full");
    // R4 sixteen bits into the narrow build, longer frame into both
    frame(32'h0000_F00F, 16, "R4 sixteen");
    frame(32'h0003_1234, 20, "R4 twenty");
    // R8 short frame merges with old contents
    frame(32'h5, 3, "R8 short");
    // R7 empty frame repeats the shift register
    frame(32'd0, 0, "R7 empty");
    // R3 clock activity with select high
    for (int i = 0; i < 6; i++) begin
      sdi = i[0]; cyc(4); sclk = 1'b1; cyc(4); sclk = 1'b0;
    end
    frame(32'd0, 0, "R3 ignored");
    // R9 clock rise together with select rise
    csN = 1'b0; cyc(4);
    clockBit(1'b0); clockBit(1'b1);
    sdi = 1'b0; cyc(4);
    sdi = 1'b1; sclk = 1'b1; csN = 1'b1;
    cyc(8);
    sclk = 1'b0;
    check("R9 wide word", 32'(dacWide), 32'(shW));
    check("R9 narrow word", 32'(dacNarrow), 32'(shN));
    cyc(4);
    // Random frames
    for (int k = 0; k < 40; k++) begin
      int len = int'($urandom_range(20, 0));
      frame($urandom, len, "R2 R4 R8 random");
    end
    check("R6 single-cycle strobes", 32'(wideViol), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule